// File: doc/BRIEF.md
# Tone Processor Configuration Bus Slave

This block receives configuration for a stereo tone and volume processor over a two-wire serial bus and holds it in eight 8-bit registers. A fast system clock samples the bus clock and data lines. The block detects bus start and stop conditions, matches one fixed device address, and acknowledges every byte it accepts. It writes the data bytes of a transfer into the register file. It only accepts writes: it never returns data, never holds the bus clock low, and never takes part in arbitration.

After the address byte, a pointer byte gives the target register and says whether the pointer steps forward after each data byte. The pointer is four bits wide. Only values 0 to 7 hold a register, so a stepping burst passes through eight empty slots before it wraps back to register 0. The block presents all register contents as one flat vector. It also gives two decoded control flags: an effective bass level-control enable, which is held off while the bass setting cuts or is flat, and an output mute flag.

Top module: `audio_cfg_i2c_slave`

## Requirements
- R1: A falling data line while the clock is high (START) always begins address matching, including in the middle of a transfer. A rising data line while the clock is high (STOP) returns the block to idle and releases the data line.
- R2: Only the address byte 0x88 (7-bit address 0x44 and the write bit 0) is acknowledged. For any other address byte, that byte and every later byte go unacknowledged, and no register changes until the next START.
- R3: Each byte is 8 bits, MSB first. On the ninth clock pulse the block pulls the data line low to acknowledge, and it changes that line only while the clock is low.
- R4: In the pointer byte, bits [3:0] give the register pointer, bit 4 enables stepping, and bits [7:5] have no effect.
- R5: Pointer values 0 through 7 select, in this order, the registers for input selection with mic, input gain, surround, left volume, right volume, tone (treble in bits [3:0], bass in bits [7:4]), output, and bass level control. Register k appears on regFlat[8k+7:8k].
- R6: When the stepping bit is 0, every data byte of the transfer is written to the same register.
- R7: When the stepping bit is 1, the first data byte goes to the pointed register, and each later byte goes to the pointer plus one.
- R8: A data byte aimed at pointer 8 to 15 is acknowledged, changes no register, and still advances a stepping pointer. The pointer wraps from 15 to 0.
- R9: Reset sets every register to 0xFE.
- R10: alcActive is 1 only when bit 0 of register 7 is 1 and the bass code in register 5 bits [7:4] has its MSB set and is not 1111.
- R11: muteOn is 1 exactly when bit 0 of register 6 is 0.
- R12: A transfer that ends with STOP after the pointer byte, with no data byte, leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaPullLow | output | 1 | 1 drives the data line low (acknowledge) |
| regFlat | output | 64 | All eight registers, register k in bits [8k+7:8k] |
| alcActive | output | 1 | Effective bass level-control enable |
| muteOn | output | 1 | Output mute is engaged |

## Verification
On the same clock-low edge that ends a data byte, the register write and the pointer step both take effect. A write to register 7 therefore lands on the same cycle in which the pointer moves into the empty slots, and a byte to slot 15 coincides with the wrap to 0. Bursts that start at pointers 6 and 14 cause both of these cases. A scoreboard then requires exactly one register change per in-range byte, with the right index and value, and no change for the bytes sent to empty slots.

// File: rtl/audio_cfg_pkg.sv
package audio_cfg_pkg;

  localparam int CFG_REGS   = 8;
  localparam int CFG_IDX_W  = $clog2(CFG_REGS);
  localparam int CFG_DATA_W = 8;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_ADDR,
    CS_SUB,
    CS_DATA,
    CS_IGNORE
  } busState_t;

  // Strobe bundle from the bus control to the register bank.
  typedef struct packed {
    logic                  wrEn;
    logic [CFG_IDX_W-1:0]  wrIdx;
    logic [CFG_DATA_W-1:0] wrData;
  } regWrite_t;

endpackage

// File: rtl/cfg_bus_ctrl.sv
module cfg_bus_ctrl
  import audio_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44,
  parameter int         PTR_W    = 4,
  parameter int         STEP_BIT = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  output logic      sdaPullLow,
  output regWrite_t wr
);

  localparam int BYTE_BITS = 8;
  localparam logic [3:0] ACK_SLOT  = 4'(BYTE_BITS);
  localparam logic [3:0] ACK_DONE  = 4'(BYTE_BITS + 1);
  localparam logic [7:0] ADDR_BYTE = {DEV_ADDR, 1'b0};

  logic [1:0] sclSync, sdaSync;
  logic       sclQ, sdaQ;
  logic       sclS, sdaS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclQ    <= sclSync[1];
      sdaQ    <= sdaSync[1];
    end
  end

  assign sclS = sclSync[1];
  assign sdaS = sdaSync[1];

  logic sclRise, sclFall, startSeen, stopSeen;
  assign sclRise   = sclS && !sclQ;
  assign sclFall   = !sclS && sclQ;
  assign startSeen = sclS && sclQ && sdaQ && !sdaS;
  assign stopSeen  = sclS && sclQ && !sdaQ && sdaS;

  busState_t        state;
  logic [3:0]       bitCnt;
  logic [7:0]       shiftReg;
  logic [PTR_W-1:0] ptr;
  logic             stepOn;
  logic             ptrInRange;
  logic             active;

  assign ptrInRange = (ptr < PTR_W'(CFG_REGS));
  assign active     = (state == CS_ADDR) || (state == CS_SUB) || (state == CS_DATA);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= CS_IDLE;
      bitCnt     <= '0;
      shiftReg   <= '0;
      ptr        <= '0;
      stepOn     <= 1'b0;
      sdaPullLow <= 1'b0;
      wr         <= '0;
    end else begin
      wr.wrEn <= 1'b0;
      if (startSeen) begin
        state      <= CS_ADDR;
        bitCnt     <= '0;
        sdaPullLow <= 1'b0;
      end else if (stopSeen) begin
        state      <= CS_IDLE;
        bitCnt     <= '0;
        sdaPullLow <= 1'b0;
      end else if (active) begin
        if (sclRise && bitCnt < ACK_SLOT) begin
          shiftReg <= {shiftReg[6:0], sdaS};
          bitCnt   <= bitCnt + 4'd1;
        end else if (sclRise && bitCnt == ACK_SLOT) begin
          bitCnt <= ACK_DONE;
        end else if (sclFall && bitCnt == ACK_SLOT) begin
          unique case (state)
            CS_ADDR: begin
              if (shiftReg == ADDR_BYTE) begin
                sdaPullLow <= 1'b1;
                state      <= CS_SUB;
              end else begin
                state <= CS_IGNORE;
              end
            end
            CS_SUB: begin
              ptr        <= shiftReg[PTR_W-1:0];
              stepOn     <= shiftReg[STEP_BIT];
              sdaPullLow <= 1'b1;
              state      <= CS_DATA;
            end
            default: begin
              sdaPullLow <= 1'b1;
              if (ptrInRange) begin
                wr.wrEn   <= 1'b1;
                wr.wrIdx  <= ptr[CFG_IDX_W-1:0];
                wr.wrData <= shiftReg;
              end
              if (stepOn) ptr <= ptr + 1'b1;
            end
          endcase
        end else if (sclFall && bitCnt == ACK_DONE) begin
          sdaPullLow <= 1'b0;
          bitCnt     <= '0;
        end
      end
    end
  end

  // R1: a STOP always leaves the slave idle with the line released.
  a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> (state == CS_IDLE) && !sdaPullLow);

  // R2: after an address mismatch the line is never pulled.
  a_r2_ignore_silent: assert property (@(posedge clk) disable iff (!rstN)
    (state == CS_IGNORE) |-> !sdaPullLow);

  // R3: the acknowledge begins only while the bus clock is low.
  a_r3_ack_on_low_clock: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclS);

  // R8: a register strobe only follows a byte taken in the data phase.
  a_r8_strobe_from_data: assert property (@(posedge clk) disable iff (!rstN)
    wr.wrEn |-> ($past(state) == CS_DATA));

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import audio_cfg_pkg::*;
#(
  parameter logic [CFG_DATA_W-1:0] RESET_VAL = 8'hFE,
  parameter int TONE_REG  = 5,
  parameter int OUT_REG   = 6,
  parameter int ALC_REG   = 7,
  parameter int BASS_LSB  = 4,
  parameter int ALC_BIT   = 0,
  parameter int MUTE_BIT  = 0
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  regWrite_t                        wr,
  output logic [CFG_REGS*CFG_DATA_W-1:0]   regFlat,
  output logic                             alcActive,
  output logic                             muteOn
);

  localparam int BASS_W = 4;

  logic [CFG_REGS*CFG_DATA_W-1:0] store;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      store <= {CFG_REGS{RESET_VAL}};
    end else if (wr.wrEn) begin
      store[wr.wrIdx*CFG_DATA_W +: CFG_DATA_W] <= wr.wrData;
    end
  end

  assign regFlat = store;

  logic [BASS_W-1:0] bassCode;
  logic              alcMode;
  logic              bassBoost;

  assign bassCode  = store[TONE_REG*CFG_DATA_W + BASS_LSB +: BASS_W];
  assign alcMode   = store[ALC_REG*CFG_DATA_W + ALC_BIT];
  assign bassBoost = bassCode[BASS_W-1] && (bassCode != {BASS_W{1'b1}});
  assign alcActive = alcMode && bassBoost;
  assign muteOn    = !store[OUT_REG*CFG_DATA_W + MUTE_BIT];

  // R12: registers move only on a strobe from the bus control.
  a_r12_stable_without_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !wr.wrEn |=> $stable(regFlat));

  // R10: a cut or flat bass setting keeps the level control off.
  a_r10_cut_forces_alc_off: assert property (@(posedge clk) disable iff (!rstN)
    !regFlat[TONE_REG*CFG_DATA_W + BASS_LSB + BASS_W - 1] |-> !alcActive);

endmodule

// File: rtl/audio_cfg_i2c_slave.sv
module audio_cfg_i2c_slave
  import audio_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           sclIn,
  input  logic                           sdaIn,
  output logic                           sdaPullLow,
  output logic [CFG_REGS*CFG_DATA_W-1:0] regFlat,
  output logic                           alcActive,
  output logic                           muteOn
);

  regWrite_t wrStrobe;

  cfg_bus_ctrl #(
    .DEV_ADDR (DEV_ADDR),
    .PTR_W    (4),
    .STEP_BIT (4)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .sdaPullLow (sdaPullLow),
    .wr         (wrStrobe)
  );

  cfg_reg_bank #(
    .RESET_VAL (8'hFE)
  ) u_bank (
    .clk       (clk),
    .rstN      (rstN),
    .wr        (wrStrobe),
    .regFlat   (regFlat),
    .alcActive (alcActive),
    .muteOn    (muteOn)
  );

endmodule

// File: tb/audio_cfg_i2c_slave_tb.sv
module audio_cfg_i2c_slave_tb;

  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaLine;
  logic sdaPullLow;
  logic [63:0] regFlat;
  logic alcActive, muteOn;

  always #5 clk = ~clk;

  assign sdaLine = sdaM & ~sdaPullLow;

  audio_cfg_i2c_slave u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclM),
    .sdaIn      (sdaLine),
    .sdaPullLow (sdaPullLow),
    .regFlat    (regFlat),
    .alcActive  (alcActive),
    .muteOn     (muteOn)
  );

  typedef struct {
    int         idx;
    logic [7:0] val;
  } expItem_t;

  expItem_t   expQ[$];
  expItem_t   popped;
  logic [7:0] txQ[$];
  logic [7:0] model[8];
  logic [63:0] prevFlat;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startC();
    sdaM = 1'b1; idle(HALF);
    sclM = 1'b1; idle(HALF);
    sdaM = 1'b0; idle(HALF);
    sclM = 1'b0; idle(HALF);
  endtask

  task automatic stopC();
    sdaM = 1'b0; idle(HALF);
    sclM = 1'b1; idle(HALF);
    sdaM = 1'b1; idle(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; idle(HALF);
      sclM = 1'b1; idle(HALF);
      sclM = 1'b0; idle(4);
    end
    sdaM = 1'b1; idle(HALF);
    sclM = 1'b1; idle(HALF / 2);
    acked = !sdaLine;
    idle(HALF / 2);
    sclM = 1'b0; idle(4);
  endtask

  // Expect a register change: pushed before the byte is sent.
  task automatic expectWrite(input int idx, input logic [7:0] val);
    if (model[idx] != val) begin
      expQ.push_back('{idx, val});
      model[idx] = val;
    end
  endtask

  task automatic doWrite(input logic [7:0] addrByte, input logic [7:0] sub,
                         input bit expAck, input string req);
    bit a;
    logic [3:0] ptr;
    startC();
    sendByte(addrByte, a);
    chk(a == expAck, req, "address ack", a, expAck);
    sendByte(sub, a);
    chk(a == expAck, req, "pointer ack", a, expAck);
    ptr = sub[3:0];
    foreach (txQ[k]) begin
      if (expAck && ptr < 4'd8) expectWrite(int'(ptr), txQ[k]);
      sendByte(txQ[k], a);
      chk(a == expAck, req, "data ack", a, expAck);
      if (sub[4]) ptr = ptr + 4'd1;
    end
    txQ.delete();
    stopC();
    idle(10);
    chk(expQ.size() == 0, req, "pending expected writes", expQ.size(), 0);
  endtask

  task automatic checkAll(input string req);
    for (int i = 0; i < 8; i++)
      chk(regFlat[i*8 +: 8] == model[i], req, $sformatf("register %0d", i),
          regFlat[i*8 +: 8], model[i]);
  endtask

  // Monitor: every register change must match the head of the scoreboard.
  always @(negedge clk) begin
    if (rstN) begin
      for (int i = 0; i < 8; i++) begin
        if (regFlat[i*8 +: 8] != prevFlat[i*8 +: 8]) begin
          if (expQ.size() == 0) begin
            chk(1'b0, "R5", $sformatf("unexpected change of register %0d", i),
                regFlat[i*8 +: 8], prevFlat[i*8 +: 8]);
          end else begin
            popped = expQ.pop_front();
            chk(popped.idx == i, "R5", "written register index", i, popped.idx);
            chk(popped.val == regFlat[i*8 +: 8], "R5", "written value",
                regFlat[i*8 +: 8], popped.val);
          end
        end
      end
    end
    prevFlat = regFlat;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R1 watchdog expired: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    bit a;
    for (int i = 0; i < 8; i++) model[i] = 8'hFE;
    idle(5);
    rstN = 1'b1;
    idle(5);

    // R9: reset values; R10/R11 flags from them.
    checkAll("R9");
    chk(alcActive == 1'b0, "R10", "alcActive after reset", alcActive, 0);
    chk(muteOn == 1'b1, "R11", "muteOn after reset", muteOn, 1);

    // R6 and R4: fixed pointer, high bits of the pointer byte set.
    txQ = '{8'h12, 8'h34};
    doWrite(8'h88, 8'hE3, 1'b1, "R6");
    chk(regFlat[3*8 +: 8] == 8'h34, "R6", "register 3 final", regFlat[3*8 +: 8], 8'h34);

    // R7 and R8: burst from 6 through empty slots and wrap to 0.
    txQ = '{8'hA1, 8'hB2, 8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5, 8'hC6, 8'hC7, 8'h55};
    doWrite(8'h88, 8'h16, 1'b1, "R7");
    checkAll("R8");

    // R8: start inside the empty range, wrap from 15.
    txQ = '{8'h66, 8'h67, 8'h68};
    doWrite(8'h88, 8'h1E, 1'b1, "R8");
    txQ = '{8'h99, 8'h9A};
    doWrite(8'h88, 8'h09, 1'b1, "R8");
    checkAll("R8");

    // R5: stepping burst over all eight registers.
    txQ = '{8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26, 8'h27};
    doWrite(8'h88, 8'h10, 1'b1, "R5");
    checkAll("R5");

    // R2: foreign address and read direction are ignored.
    txQ = '{8'h01, 8'h02};
    doWrite(8'h8A, 8'h00, 1'b0, "R2");
    txQ = '{8'h03};
    doWrite(8'h89, 8'h11, 1'b0, "R2");
    checkAll("R2");

    // R1: repeated START in the middle of a transfer.
    startC();
    sendByte(8'h88, a); chk(a, "R1", "address ack", a, 1);
    sendByte(8'h02, a); chk(a, "R1", "pointer ack", a, 1);
    expectWrite(2, 8'h3C);
    sendByte(8'h3C, a); chk(a, "R1", "data ack", a, 1);
    startC();
    sendByte(8'h88, a); chk(a, "R1", "address ack after restart", a, 1);
    sendByte(8'h01, a);
    expectWrite(1, 8'h77);
    sendByte(8'h77, a);
    stopC(); idle(10);
    // R1: mismatch, then restart with the right address.
    startC();
    sendByte(8'h90, a); chk(!a, "R1", "foreign address ack", a, 0);
    startC();
    sendByte(8'h88, a); chk(a, "R1", "address ack after mismatch", a, 1);
    sendByte(8'h04, a);
    expectWrite(4, 8'h4D);
    sendByte(8'h4D, a);
    stopC(); idle(10);
    chk(sdaPullLow == 1'b0, "R1", "line released after STOP", sdaPullLow, 0);
    checkAll("R1");

    // R12: STOP right after the pointer byte.
    txQ.delete();
    doWrite(8'h88, 8'h00, 1'b1, "R12");
    checkAll("R12");

    // R10: effective level-control enable.
    txQ = '{8'h87}; doWrite(8'h88, 8'h05, 1'b1, "R10");
    txQ = '{8'h01}; doWrite(8'h88, 8'h07, 1'b1, "R10");
    chk(alcActive == 1'b1, "R10", "boost and mode on", alcActive, 1);
    txQ = '{8'h77}; doWrite(8'h88, 8'h05, 1'b1, "R10");
    chk(alcActive == 1'b0, "R10", "cut code 0111", alcActive, 0);
    txQ = '{8'hF7}; doWrite(8'h88, 8'h05, 1'b1, "R10");
    chk(alcActive == 1'b0, "R10", "flat code 1111", alcActive, 0);
    txQ = '{8'h97}; doWrite(8'h88, 8'h05, 1'b1, "R10");
    chk(alcActive == 1'b1, "R10", "boost code 1001", alcActive, 1);
    txQ = '{8'h00}; doWrite(8'h88, 8'h07, 1'b1, "R10");
    chk(alcActive == 1'b0, "R10", "mode bit off", alcActive, 0);

    // R11: mute flag.
    txQ = '{8'h01}; doWrite(8'h88, 8'h06, 1'b1, "R11");
    chk(muteOn == 1'b0, "R11", "mute released", muteOn, 0);
    txQ = '{8'h00}; doWrite(8'h88, 8'h06, 1'b1, "R11");
    chk(muteOn == 1'b1, "R11", "mute engaged", muteOn, 1);

    checkAll("R5");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule